// File: doc/BRIEF.md
# Radix Translation Context Selector

This block sits at the front of a radix address-translation pipeline. For each request it takes a 64-bit effective address, an access kind, a hypervisor-state flag and a relocation flag, together with the current partition-identifier and process-identifier registers and the hypervisor real-mode offset register. It decides which translation context the access belongs to. The context is the effective partition ID and process ID, and it is chosen from the two most significant address bits (the quadrant). The block may instead decide that the access cannot be translated and must raise a segment fault.

A hypervisor access with relocation off bypasses context selection altogether. The block forms the real address at once and grants full permission. All other accesses, including guest accesses with relocation off, go through the quadrant decode. The table walk and the permission checks that follow are done by other logic.

Every result is registered. A response appears, with a one-cycle valid pulse, on the clock edge after the request strobe. It stays on the outputs until the next request.

Top module: `radix_ctx_sel`

## Requirements
- R1: While reset is high and after it, until the first request, every output is zero.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` was sampled high, and low otherwise.
- R3: For an access that is not hypervisor real mode, a nonzero bit anywhere in `req_ea[61:52]` gives a segment fault, whatever the quadrant.
- R4: With `req_hv`=1 and quadrant `req_ea[63:62]`=0, the output IDs are lpid 0 with the PID register. With quadrant 1 they are the LPID register with the PID register.
- R5: With `req_hv`=1, quadrant 2 gives the LPID register with pid 0, and quadrant 3 gives lpid 0 with pid 0.
- R6: With `req_hv`=0, quadrant 0 gives the LPID and PID registers, and quadrant 3 gives the LPID register with pid 0. This holds whatever the value of `req_reloc`.
- R7: With `req_hv`=0, quadrants 1 and 2 give a segment fault.
- R8: Access encoding is 0 = load, 1 = store, 2 = fetch; 3 is treated as data. A segment fault on a fetch reports `rsp_fault_data`=0 and `rsp_fault_addr`=0. On any other access it reports `rsp_fault_data`=1 and `rsp_fault_addr`=the effective address. A faulted response carries zero IDs, a zero real address and zero permission.
- R9: With `req_hv`=1 and `req_reloc`=0, the response has `rsp_real`=1 and `rsp_perm`=3'b111 (bit 2 read, bit 1 write, bit 0 execute). It also has no fault, zero IDs, and a real address equal to the effective address with bits 63:60 cleared, before any offset merge.
- R10: In that real-mode case, the offset register is ORed into the real address only when `req_ea[63]`=0.
- R11: In that real-mode case, bits 61:52 of the address are ignored and cause no fault.
- R12: A translated (non-real, non-faulted) response has `rsp_real`=0, a zero real address and zero permission. Without a request, all outputs keep their values.

Quadrant selection and range screening are combinational. The response register is the only stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_hv | input | 1 | Hypervisor state |
| req_reloc | input | 1 | Relocation enabled |
| cur_lpid | input | 12 | Partition-ID register |
| cur_pid | input | 20 | Process-ID register |
| rm_offset | input | 64 | Hypervisor real-mode offset register |
| rsp_valid | output | 1 | Response pulse |
| rsp_lpid | output | 12 | Selected partition ID |
| rsp_pid | output | 20 | Selected process ID |
| rsp_real | output | 1 | Response is a real-mode address |
| rsp_raddr | output | 64 | Real-mode address |
| rsp_perm | output | 3 | Granted read/write/execute |
| rsp_fault | output | 1 | Segment fault |
| rsp_fault_data | output | 1 | Fault type: 0 instruction, 1 data |
| rsp_fault_addr | output | 64 | Captured data-fault address |

## Verification
The response register is the only state, so any error inside it shows up in full on the ports in the cycle after the request that caused it. A swapped quadrant row, for example, gives wrong IDs on the very next response. A wrong bit in the range screen turns a legal access into a fault, or a faulting one into a legal one, at once. The bench runs a behavioural model beside the block and compares every output on every clock. A corrupted hold therefore shows up in the first idle cycle, and a missing or doubled valid pulse shows up in the cycle where it happens.

// File: rtl/radix_ctx_pkg.sv
package radix_ctx_pkg;

    localparam int EA_W     = 64;
    localparam int LPID_W   = 12;
    localparam int PID_W    = 20;
    localparam int QUAD_W   = 2;
    localparam int SCREEN_W = 10;
    localparam int CLR_TOP  = 4;
    localparam int PERM_W   = 3;

    localparam int QUAD_LO   = EA_W - QUAD_W;
    localparam int SCREEN_HI = QUAD_LO - 1;
    localparam int SCREEN_LO = QUAD_LO - SCREEN_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic {
        FK_INSN = 1'b0,
        FK_DATA = 1'b1
    } fault_kind_e;

    typedef struct packed {
        logic              fault;
        fault_kind_e       kind;
        logic              real_mode;
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
        logic [EA_W-1:0]   raddr;
        logic [PERM_W-1:0] perm;
        logic [EA_W-1:0]   fault_addr;
    } ctx_rsp_t;

    localparam logic [PERM_W-1:0] PERM_ALL = '1;

    function automatic fault_kind_e kind_of(input acc_e a);
        return (a == ACC_FETCH) ? FK_INSN : FK_DATA;
    endfunction

    function automatic ctx_rsp_t rsp_zero();
        ctx_rsp_t r;
        r = '0;
        return r;
    endfunction

endpackage

// File: rtl/radix_ea_screen.sv
module radix_ea_screen
    import radix_ctx_pkg::*;
(
    input  logic [EA_W-1:0] ea,
    output logic            in_range
);
    logic [SCREEN_W-1:0] field;

    for (genvar i = 0; i < SCREEN_W; i++) begin : g_bit
        assign field[i] = ea[SCREEN_LO + i];
    end

    assign in_range = (field == '0);
endmodule

// File: rtl/radix_quadrant_map.sv
module radix_quadrant_map
    import radix_ctx_pkg::*;
(
    input  logic [QUAD_W-1:0] quad,
    input  logic              hv,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic              legal,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid
);
    always_comb begin
        legal = 1'b1;
        lpid  = '0;
        pid   = '0;
        if (hv) begin
            unique case (quad)
                2'd0: pid = pid_reg;
                2'd1: begin lpid = lpid_reg; pid = pid_reg; end
                2'd2: lpid = lpid_reg;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin lpid = lpid_reg; pid = pid_reg; end
                2'd3: lpid = lpid_reg;
                default: legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/radix_real_addr.sv
module radix_real_addr
    import radix_ctx_pkg::*;
(
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] offset,
    output logic [EA_W-1:0] raddr
);
    localparam logic [EA_W-1:0] KEEP_MASK = {{CLR_TOP{1'b0}}, {(EA_W-CLR_TOP){1'b1}}};

    logic merge;
    assign merge = ~ea[EA_W-1];
    assign raddr = (ea & KEEP_MASK) | (merge ? offset : '0);
endmodule

// File: rtl/radix_ctx_sel.sv
module radix_ctx_sel
    import radix_ctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_acc,
    input  logic              req_hv,
    input  logic              req_reloc,
    input  logic [LPID_W-1:0] cur_lpid,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic [EA_W-1:0]   rm_offset,
    output logic              rsp_valid,
    output logic [LPID_W-1:0] rsp_lpid,
    output logic [PID_W-1:0]  rsp_pid,
    output logic              rsp_real,
    output logic [EA_W-1:0]   rsp_raddr,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_fault,
    output logic              rsp_fault_data,
    output logic [EA_W-1:0]   rsp_fault_addr
);
    logic              in_range;
    logic              q_legal;
    logic [LPID_W-1:0] q_lpid;
    logic [PID_W-1:0]  q_pid;
    logic [EA_W-1:0]   rm_addr;
    logic              real_path;
    acc_e              acc;
    ctx_rsp_t          nxt, cur;

    assign acc = acc_e'(req_acc);

    radix_ea_screen u_screen (
        .ea       (req_ea),
        .in_range (in_range)
    );

    radix_quadrant_map u_qmap (
        .quad     (req_ea[EA_W-1:QUAD_LO]),
        .hv       (req_hv),
        .lpid_reg (cur_lpid),
        .pid_reg  (cur_pid),
        .legal    (q_legal),
        .lpid     (q_lpid),
        .pid      (q_pid)
    );

    radix_real_addr u_rm (
        .ea     (req_ea),
        .offset (rm_offset),
        .raddr  (rm_addr)
    );

    assign real_path = req_hv & ~req_reloc;

    always_comb begin
        nxt = rsp_zero();
        if (real_path) begin
            nxt.real_mode = 1'b1;
            nxt.raddr     = rm_addr;
            nxt.perm      = PERM_ALL;
        end else if (!in_range || !q_legal) begin
            nxt.fault = 1'b1;
            nxt.kind  = kind_of(acc);
            if (kind_of(acc) == FK_DATA) begin
                nxt.fault_addr = req_ea;
            end
        end else begin
            nxt.lpid = q_lpid;
            nxt.pid  = q_pid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= rsp_zero();
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                cur <= nxt;
            end
        end
    end

    assign rsp_lpid       = cur.lpid;
    assign rsp_pid        = cur.pid;
    assign rsp_real       = cur.real_mode;
    assign rsp_raddr      = cur.raddr;
    assign rsp_perm       = cur.perm;
    assign rsp_fault      = cur.fault;
    assign rsp_fault_data = cur.kind;
    assign rsp_fault_addr = cur.fault_addr;
endmodule

// File: rtl/radix_ctx_sel_chk.sv
module radix_ctx_sel_chk
    import radix_ctx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [EA_W-1:0]   req_ea,
    input logic [1:0]        req_acc,
    input logic              req_hv,
    input logic              req_reloc,
    input logic              rsp_valid,
    input logic [LPID_W-1:0] rsp_lpid,
    input logic [PID_W-1:0]  rsp_pid,
    input logic              rsp_real,
    input logic [EA_W-1:0]   rsp_raddr,
    input logic [PERM_W-1:0] rsp_perm,
    input logic              rsp_fault,
    input logic              rsp_fault_data,
    input logic [EA_W-1:0]   rsp_fault_addr
);
    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r3_screen_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_hv && !req_reloc) && (req_ea[SCREEN_HI:SCREEN_LO] != '0))
        |=> rsp_fault);

    a_r7_guest_illegal: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_hv && (req_ea[EA_W-1:QUAD_LO] inside {2'd1, 2'd2}))
        |=> (rsp_fault && rsp_lpid == '0 && rsp_pid == '0));

    a_r8_fetch_no_addr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_hv && !req_reloc) && req_acc == 2'd2)
        |=> (!rsp_fault_data && rsp_fault_addr == '0));

    a_r9_real_grant: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_hv && !req_reloc)
        |=> (rsp_real && rsp_perm == '1 && !rsp_fault));

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_lpid) && $stable(rsp_pid) && $stable(rsp_raddr)
                        && $stable(rsp_fault) && $stable(rsp_real)));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_real && rsp_fault));
endmodule

bind radix_ctx_sel radix_ctx_sel_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ea         (req_ea),
    .req_acc        (req_acc),
    .req_hv         (req_hv),
    .req_reloc      (req_reloc),
    .rsp_valid      (rsp_valid),
    .rsp_lpid       (rsp_lpid),
    .rsp_pid        (rsp_pid),
    .rsp_real       (rsp_real),
    .rsp_raddr      (rsp_raddr),
    .rsp_perm       (rsp_perm),
    .rsp_fault      (rsp_fault),
    .rsp_fault_data (rsp_fault_data),
    .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/radix_ctx_sel_tb_top.sv
module radix_ctx_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_ea = '0;
    logic [1:0]  req_acc = '0;
    logic        req_hv = 1'b0;
    logic        req_reloc = 1'b0;
    logic [11:0] cur_lpid = 12'h5A3;
    logic [19:0] cur_pid = 20'hC0DE7;
    logic [63:0] rm_offset = 64'h0000_0000_4000_0000;

    logic        rsp_valid;
    logic [11:0] rsp_lpid;
    logic [19:0] rsp_pid;
    logic        rsp_real;
    logic [63:0] rsp_raddr;
    logic [2:0]  rsp_perm;
    logic        rsp_fault;
    logic        rsp_fault_data;
    logic [63:0] rsp_fault_addr;

    radix_ctx_sel dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
        .req_acc(req_acc), .req_hv(req_hv), .req_reloc(req_reloc),
        .cur_lpid(cur_lpid), .cur_pid(cur_pid), .rm_offset(rm_offset),
        .rsp_valid(rsp_valid), .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid),
        .rsp_real(rsp_real), .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm),
        .rsp_fault(rsp_fault), .rsp_fault_data(rsp_fault_data),
        .rsp_fault_addr(rsp_fault_addr)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // behavioural expectation, updated on each rising edge
    logic        e_valid = 0, e_real = 0, e_fault = 0, e_fdata = 0;
    logic [11:0] e_lpid = 0;
    logic [19:0] e_pid = 0;
    logic [63:0] e_raddr = 0, e_faddr = 0;
    logic [2:0]  e_perm = 0;

    always @(posedge clk) begin
        if (rst) begin
            e_valid = 0; e_real = 0; e_fault = 0; e_fdata = 0;
            e_lpid = 0; e_pid = 0; e_raddr = 0; e_faddr = 0; e_perm = 0;
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                int q;
                bit bad;
                q = int'(req_ea >> 62);
                e_real = 0; e_fault = 0; e_fdata = 0;
                e_lpid = 0; e_pid = 0; e_raddr = 0; e_faddr = 0; e_perm = 0;
                if (req_hv && !req_reloc) begin
                    e_real  = 1;
                    e_perm  = 3'b111;
                    e_raddr = req_ea % (64'd1 << 60);
                    if (req_ea < (64'd1 << 63)) e_raddr = e_raddr | rm_offset;
                end else begin
                    bad = ((req_ea >> 52) % 1024) != 0;
                    if (!req_hv && (q == 1 || q == 2)) bad = 1;
                    if (bad) begin
                        e_fault = 1;
                        if (req_acc != 2) begin
                            e_fdata = 1;
                            e_faddr = req_ea;
                        end
                    end else if (req_hv) begin
                        if (q == 1 || q == 2) e_lpid = cur_lpid;
                        if (q == 0 || q == 1) e_pid = cur_pid;
                    end else begin
                        e_lpid = cur_lpid;
                        if (q == 0) e_pid = cur_pid;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_lpid !== e_lpid || rsp_pid !== e_pid ||
                rsp_real !== e_real || rsp_raddr !== e_raddr || rsp_perm !== e_perm ||
                rsp_fault !== e_fault || rsp_fault_data !== e_fdata ||
                rsp_fault_addr !== e_faddr) begin
                errors++;
                $display("FAIL %s: got v%0b l%h p%h r%0b a%h pm%b f%0b d%0b fa%h exp v%0b l%h p%h r%0b a%h pm%b f%0b d%0b fa%h",
                    tag, rsp_valid, rsp_lpid, rsp_pid, rsp_real, rsp_raddr, rsp_perm,
                    rsp_fault, rsp_fault_data, rsp_fault_addr,
                    e_valid, e_lpid, e_pid, e_real, e_raddr, e_perm, e_fault, e_fdata, e_faddr);
            end
        end
    end

    task automatic send(input string t, input logic [63:0] ea, input logic [1:0] acc,
                        input logic hv, input logic reloc);
        @(negedge clk);
        tag = t;
        req_valid = 1'b1; req_ea = ea; req_acc = acc; req_hv = hv; req_reloc = reloc;
        @(negedge clk);
        req_valid = 1'b0;
        req_ea = ~ea; req_hv = ~hv;
    endtask

    task automatic idle(input string t, input int n);
        @(negedge clk);
        tag = t;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1", 2);
        // R4 / R5: hypervisor quadrants
        for (int q = 0; q < 4; q++)
            send(q < 2 ? "R4" : "R5", {q[1:0], 62'h0000_1234_5678}, 2'd0, 1'b1, 1'b1);
        // R6: guest legal quadrants, both relocation settings
        send("R6", {2'd0, 62'h0000_0000_ABC0}, 2'd0, 1'b0, 1'b1);
        send("R6", {2'd3, 62'h0000_0000_ABC0}, 2'd1, 1'b0, 1'b1);
        send("R6", {2'd0, 62'h0000_0000_0040}, 2'd2, 1'b0, 1'b0);
        // R7: guest illegal quadrants
        send("R7", {2'd1, 62'h0000_0000_1000}, 2'd0, 1'b0, 1'b1);
        send("R7", {2'd2, 62'h0000_0000_2000}, 2'd2, 1'b0, 1'b0);
        // R3: screened bits, lowest and highest
        send("R3", 64'h0010_0000_0000_0000, 2'd1, 1'b1, 1'b1);
        send("R3", 64'h2000_0000_0000_0000, 2'd0, 1'b0, 1'b1);
        send("R3", 64'hC100_0000_0000_0000, 2'd0, 1'b1, 1'b1);
        // R8: fault type per access kind
        send("R8", 64'h4000_0000_0000_0100, 2'd2, 1'b0, 1'b1);
        send("R8", 64'h4000_0000_0000_0200, 2'd1, 1'b0, 1'b1);
        send("R8", 64'h4000_0000_0000_0300, 2'd3, 1'b0, 1'b1);
        // R9 / R10 / R11: hypervisor real mode
        send("R9", 64'h7000_0000_0012_3400, 2'd0, 1'b1, 1'b0);
        send("R10", 64'h8000_0000_0000_5000, 2'd2, 1'b1, 1'b0);
        rm_offset = 64'h0000_0001_0000_0000;
        send("R10", 64'h0000_0000_0000_6000, 2'd1, 1'b1, 1'b0);
        send("R11", 64'hF3FF_0000_0000_0008, 2'd0, 1'b1, 1'b0);
        // R12: hold while idle, after a translated response
        send("R12", {2'd1, 62'h77}, 2'd0, 1'b1, 1'b1);
        cur_lpid = 12'h001; cur_pid = 20'h00002;
        idle("R12", 4);
        // R2: back-to-back requests
        @(negedge clk);
        tag = "R2";
        req_valid = 1'b1; req_hv = 1'b0; req_reloc = 1'b1; req_acc = 2'd0;
        req_ea = 64'h0;
        @(negedge clk);
        req_ea = 64'hC000_0000_0000_0000;
        @(negedge clk);
        req_ea = 64'h4000_0000_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        idle("R2", 2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule